// File: doc/BRIEF.md
# PHY Link State Qualifier

This block turns a stream of basic-status words read from an Ethernet PHY, together with a small vector of vendor status flags, into a debounced link state. The state is one of DOWN, UP or UNKNOWN, and it comes with the negotiated speed and duplex. Something outside the block performs the management reads. Each time a fresh 16-bit status word arrives, that logic raises a one-cycle strobe with it. The block keeps the last word it saw and stamps the time of every change with a free-running tick counter, which advances on `tick_en`. One clock after each strobe it evaluates a new state.

The acceptance rules lean towards caution when a link comes up and react quickly when it goes down:

- A lost link on an UP port is taken at once.
- A link that looks up is held as UNKNOWN until the status word has stayed unchanged for `SETTLE_TICKS` ticks. Several changes inside that window therefore merge into one.
- When autonegotiation is enabled, the block also waits for autonegotiation to complete.
- The vendor flags must agree before UP is accepted: link and signal-detect both set, and exactly one rate flag set.

Only transitions that enter or leave UP are reported. Each report raises a one-cycle pulse, updates speed and duplex, and bumps one of two event counters.

The control is a three-state machine:

- States: DOWN, UP and UNKNOWN.
- Named transitions:
  - GAIN (UNKNOWN or DOWN to UP)
  - DROP (UP to DOWN)
  - STALL (UP to UNKNOWN)
  - QUIET (between DOWN and UNKNOWN, not reported)
  - HOLD (no change)

Top module: `lq_link_qualifier`

## Requirements
- R1: A strobed status word that differs from the stored word replaces it, and the tick time of that change becomes the start of the settle window. A later change restarts the window, so changes inside one window merge.
- R2: The status word carries link-up at bit 2 and autonegotiation-complete at bit 5. Absent other rules, the apparent state is UP when bit 2 is set and DOWN when it is clear.
- R3: A stored status word of 0xFFFF always yields DOWN.
- R4: In state UP, a stored word with bit 2 clear yields DOWN at once, whether or not the settle window has passed.
- R5: Outside the cases of R3 and R4, the result is UNKNOWN until at least `SETTLE_TICKS` `tick_en` pulses have occurred since the last change of the stored word.
- R6: Once settled, if bit 5 is clear and `an_enable` is 1, the result is DOWN. With `an_enable` 0, bit 5 is ignored.
- R7: A candidate UP becomes UNKNOWN unless both of these hold:
  - `vend_stat[0]` (link) and `vend_stat[1]` (signal detect) are both 1.
  - Exactly one of `vend_stat[2]` (10M) and `vend_stat[3]` (100M) is 1.
- R8: A change into or out of UP raises `change_pulse` and updates speed and duplex. A change between DOWN and UNKNOWN raises nothing and leaves them unchanged. The encodings are:
  - State: DOWN=0, UP=1, UNKNOWN=2.
  - Speed: 0 none, 1 10M, 2 100M. On UP it is 2 if `vend_stat[3]` is set, else 1.
  - Duplex: 0 unknown, 1 half, 2 full. On UP it is 2 if `vend_stat[4]` is set, else 1.
  - Leaving UP sets speed 0 and duplex 0.
- R9: Each report into UP increments `up_count`. Each other report increments `drop_count`. The counters wrap.
- R10: After reset the state is UNKNOWN, speed and duplex are 0, both counters are 0, `change_pulse` is 0, and the stored word is 0.
- R11: The state, speed, duplex and counters change only on the second rising edge after a strobe, and `change_pulse` is high for exactly the one cycle after that edge.
- R12: Once the window has passed with no change, the result stays settled however long the tick counter runs, including across its wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advances the time-base counter by one |
| smp_valid | input | 1 | Strobe: `smp_word` holds a fresh status read |
| smp_word | input | 16 | PHY basic-status word |
| an_enable | input | 1 | Autonegotiation is enabled in the PHY configuration |
| vend_stat | input | 5 | Vendor flags: [0] link, [1] signal, [2] 10M, [3] 100M, [4] full duplex |
| link_state | output | 2 | Current state (DOWN=0, UP=1, UNKNOWN=2) |
| link_speed | output | 2 | 0 none, 1 10M, 2 100M |
| link_duplex | output | 2 | 0 unknown, 1 half, 2 full |
| change_pulse | output | 1 | One-cycle report of a transition into or out of UP |
| up_count | output | CNT_W | Number of reported transitions into UP |
| drop_count | output | CNT_W | Number of other reported transitions |

## Verification
The word is stored on the rising edge that sees the strobe. The verdict lands on the next rising edge, so state, speed, duplex, counters and the pulse are all due two edges after the strobe. The bench therefore drives the strobe at a falling edge. It checks at the falling edge after the first rising edge that nothing has moved yet and that the previous pulse has cleared. It then checks every output at the falling edge after the second rising edge. The settled flag registers the tick count one edge late, so every batch of ticks is followed by an idle cycle before the next strobe. An arithmetic model in the bench, advanced only by the ticks it drives, predicts each outcome over a sweep of all vendor flag, autonegotiation-enable and completion combinations.

// File: rtl/lq_pkg.sv
package lq_pkg;
    typedef enum logic [1:0] {
        LS_DOWN    = 2'd0,
        LS_UP      = 2'd1,
        LS_UNKNOWN = 2'd2
    } link_st_e;

    typedef enum logic [1:0] {
        SPD_NONE = 2'd0,
        SPD_10   = 2'd1,
        SPD_100  = 2'd2
    } spd_e;

    typedef enum logic [1:0] {
        DPX_UNKNOWN = 2'd0,
        DPX_HALF    = 2'd1,
        DPX_FULL    = 2'd2
    } dpx_e;

    localparam int SW_W          = 16;
    localparam int SW_LINK_BIT   = 2;
    localparam int SW_ANDONE_BIT = 5;
    localparam logic [SW_W-1:0] SW_INVALID = 16'hFFFF;

    localparam int VS_W    = 5;
    localparam int VS_LINK = 0;
    localparam int VS_SIG  = 1;
    localparam int VS_10   = 2;
    localparam int VS_100  = 3;
    localparam int VS_FDX  = 4;
endpackage

// File: rtl/lq_settle_timer.sv
module lq_settle_timer
    import lq_pkg::*;
#(
    parameter int TICK_W       = 16,
    parameter int SETTLE_TICKS = 3000   // must be at least 1 and below 2**TICK_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            smp_valid,
    input  logic [SW_W-1:0] smp_word,
    output logic [SW_W-1:0] stored_word,
    output logic            settled
);
    localparam logic [TICK_W-1:0] SETTLE_L = TICK_W'(SETTLE_TICKS);
    localparam logic [TICK_W-1:0] ONE_L    = TICK_W'(1);

    logic [TICK_W-1:0] now_q;
    logic [TICK_W-1:0] stamp_q;
    logic [TICK_W-1:0] elapsed;
    logic [SW_W-1:0]   word_q;
    logic              settled_q;
    logic              changed;

    assign changed = smp_valid && (smp_word != word_q);
    // modular difference: correct across wrap while below 2**TICK_W
    assign elapsed = now_q - stamp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= '0;
        end else if (tick_en) begin
            now_q <= now_q + ONE_L;
        end
    end

    // Sticky flag: elapsed climbs by one per tick, so it reaches the limit
    // before it could wrap; after that the flag holds until the next change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= '0;
            stamp_q   <= '0;
            settled_q <= 1'b0;
        end else if (changed) begin
            word_q    <= smp_word;
            stamp_q   <= now_q;
            settled_q <= 1'b0;
        end else if (elapsed >= SETTLE_L) begin
            settled_q <= 1'b1;
        end
    end

    assign stored_word = word_q;
    assign settled     = settled_q;

    AST_STORE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> (stored_word == $past(smp_word))); // R1
    AST_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> !settled); // R5
    AST_SETTLED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !changed) |=> settled); // R12
endmodule

// File: rtl/lq_decide.sv
module lq_decide
    import lq_pkg::*;
(
    input  logic [SW_W-1:0] word,
    input  logic            settled,
    input  logic            an_en,
    input  logic [VS_W-1:0] vs,
    input  link_st_e        cur,
    output link_st_e        cand,
    output spd_e            spd,
    output dpx_e            dpx
);
    logic vendor_ok;

    assign vendor_ok = vs[VS_LINK] && vs[VS_SIG] && (vs[VS_10] != vs[VS_100]);

    always_comb begin
        cand = word[SW_LINK_BIT] ? LS_UP : LS_DOWN;
        if (word == SW_INVALID) begin
            cand = LS_DOWN;
        end else if (cur == LS_UP && !word[SW_LINK_BIT]) begin
            cand = LS_DOWN;
        end else if (!settled) begin
            cand = LS_UNKNOWN;
        end else if (!word[SW_ANDONE_BIT] && an_en) begin
            cand = LS_DOWN;
        end
        if (cand == LS_UP && !vendor_ok) begin
            cand = LS_UNKNOWN;
        end
    end

    assign spd = vs[VS_100] ? SPD_100 : SPD_10;
    assign dpx = vs[VS_FDX] ? DPX_FULL : DPX_HALF;
endmodule

// File: rtl/lq_event_ctr.sv
module lq_event_ctr #(
    parameter int CNT_W = 16,
    parameter int N_EVT = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_EVT-1:0]       bump,
    output logic [N_EVT*CNT_W-1:0] counts
);
    localparam logic [CNT_W-1:0] INC = CNT_W'(1);

    for (genvar g = 0; g < N_EVT; g++) begin : g_ctr
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (bump[g]) begin
                cnt_q <= cnt_q + INC;
            end
        end
        assign counts[g*CNT_W +: CNT_W] = cnt_q;
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bump)); // R9
endmodule

// File: rtl/lq_link_qualifier.sv
module lq_link_qualifier
    import lq_pkg::*;
#(
    parameter int TICK_W       = 16,
    parameter int SETTLE_TICKS = 3000,
    parameter int CNT_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             smp_valid,
    input  logic [15:0]      smp_word,
    input  logic             an_enable,
    input  logic [4:0]       vend_stat,
    output logic [1:0]       link_state,
    output logic [1:0]       link_speed,
    output logic [1:0]       link_duplex,
    output logic             change_pulse,
    output logic [CNT_W-1:0] up_count,
    output logic [CNT_W-1:0] drop_count
);
    localparam int N_EVT = 2;
    localparam int EV_UP = 0;
    localparam int EV_DN = 1;

    logic [SW_W-1:0]        stored_word;
    logic                   settled;
    logic                   eval_q;
    link_st_e               state_q;
    link_st_e               cand;
    spd_e                   cand_spd;
    dpx_e                   cand_dpx;
    spd_e                   speed_q;
    dpx_e                   duplex_q;
    logic                   report_q;
    logic                   is_report;
    logic [N_EVT-1:0]       bump;
    logic [N_EVT*CNT_W-1:0] counts;

    lq_settle_timer #(
        .TICK_W       (TICK_W),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .smp_valid   (smp_valid),
        .smp_word    (smp_word),
        .stored_word (stored_word),
        .settled     (settled)
    );

    lq_decide u_decide (
        .word    (stored_word),
        .settled (settled),
        .an_en   (an_enable),
        .vs      (vend_stat),
        .cur     (state_q),
        .cand    (cand),
        .spd     (cand_spd),
        .dpx     (cand_dpx)
    );

    // evaluate the cycle after the word has been stored
    always_ff @(posedge clk) begin
        if (!rst_n) eval_q <= 1'b0;
        else        eval_q <= smp_valid;
    end

    // GAIN / DROP / STALL are reported; QUIET and HOLD are not
    assign is_report = eval_q && (cand != state_q) &&
                       (cand == LS_UP || state_q == LS_UP);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_UNKNOWN;
        end else if (eval_q) begin
            state_q <= cand;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            report_q <= 1'b0;
            speed_q  <= SPD_NONE;
            duplex_q <= DPX_UNKNOWN;
        end else begin
            report_q <= is_report;
            if (is_report) begin
                unique case (cand)
                    LS_UP: begin
                        speed_q  <= cand_spd;
                        duplex_q <= cand_dpx;
                    end
                    LS_DOWN, LS_UNKNOWN: begin
                        speed_q  <= SPD_NONE;
                        duplex_q <= DPX_UNKNOWN;
                    end
                    default: begin
                        speed_q  <= SPD_NONE;
                        duplex_q <= DPX_UNKNOWN;
                    end
                endcase
            end
        end
    end

    assign bump[EV_UP] = is_report && (cand == LS_UP);
    assign bump[EV_DN] = is_report && (cand != LS_UP);

    lq_event_ctr #(
        .CNT_W (CNT_W),
        .N_EVT (N_EVT)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump   (bump),
        .counts (counts)
    );

    assign link_state   = state_q;
    assign link_speed   = speed_q;
    assign link_duplex  = duplex_q;
    assign change_pulse = report_q;
    assign up_count     = counts[EV_UP*CNT_W +: CNT_W];
    assign drop_count   = counts[EV_DN*CNT_W +: CNT_W];

    AST_INVALID_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_q && stored_word == SW_INVALID) |=> (state_q == LS_DOWN)); // R3
    AST_DROP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_q && state_q == LS_UP && !stored_word[SW_LINK_BIT]) |=> (state_q == LS_DOWN)); // R4
    AST_UNSETTLED_NOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_q && !settled) |=> (state_q != LS_UP)); // R5
    AST_UP_HAS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_UP) |-> (speed_q != SPD_NONE && duplex_q != DPX_UNKNOWN)); // R8
    AST_REPORT_TOUCHES_UP: assert property (@(posedge clk) disable iff (!rst_n)
        report_q |-> (state_q == LS_UP || $past(state_q) == LS_UP)); // R8
    AST_HOLD_NO_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_q |=> $stable(state_q)); // R11
endmodule

// File: tb/tb_lq_link_qualifier.sv
module tb_lq_link_qualifier;
    localparam int CLK_PERIOD = 10;
    localparam int TW         = 4;
    localparam int SETTLE     = 6;
    localparam int CW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          smp_valid = 1'b0;
    logic [15:0]   smp_word = '0;
    logic          an_enable = 1'b0;
    logic [4:0]    vend_stat = '0;
    logic [1:0]    link_state;
    logic [1:0]    link_speed;
    logic [1:0]    link_duplex;
    logic          change_pulse;
    logic [CW-1:0] up_count;
    logic [CW-1:0] drop_count;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    int          m_state = 2;
    int          m_spd = 0;
    int          m_dpx = 0;
    int          m_up = 0;
    int          m_drop = 0;
    int          m_pulse = 0;
    logic [15:0] m_word = '0;
    int          m_age = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lq_link_qualifier #(
        .TICK_W       (TW),
        .SETTLE_TICKS (SETTLE),
        .CNT_W        (CW)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .smp_valid    (smp_valid),
        .smp_word     (smp_word),
        .an_enable    (an_enable),
        .vend_stat    (vend_stat),
        .link_state   (link_state),
        .link_speed   (link_speed),
        .link_duplex  (link_duplex),
        .change_pulse (change_pulse),
        .up_count     (up_count),
        .drop_count   (drop_count)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_cand(input logic [15:0] w, input logic [4:0] vs,
                                      input logic an, input int cur, input bit settled);
        int c;
        c = w[2] ? 1 : 0;
        if (w == 16'hFFFF) return 0;
        if (cur == 1 && !w[2]) return 0;
        if (!settled) return 2;
        if (!w[5] && an) c = 0;
        if (c == 1 && (!(vs[0] && vs[1]) || (vs[2] == vs[3]))) c = 2;
        return c;
    endfunction

    task automatic advance(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
            @(negedge clk);
            m_age = (m_age + n > 1000) ? 1000 : m_age + n;
        end
    endtask

    task automatic sample(input logic [15:0] w, input logic [4:0] vs,
                          input logic an, input string tag);
        int prev;
        int nc;
        prev = m_state;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_word  = w;
        vend_stat = vs;
        an_enable = an;
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R11", "state before verdict edge", int'(link_state), prev);
        chk("R11", "pulse lasts one cycle", int'(change_pulse), 0);
        if (w != m_word) begin
            m_word = w;
            m_age  = 0;
        end
        nc = model_cand(w, vs, an, m_state, m_age >= SETTLE);
        m_pulse = 0;
        if (nc != m_state) begin
            if (nc == 1 || m_state == 1) begin
                m_pulse = 1;
                if (nc == 1) begin
                    m_up++;
                    m_spd = vs[3] ? 2 : 1;
                    m_dpx = vs[4] ? 2 : 1;
                end else begin
                    m_drop++;
                    m_spd = 0;
                    m_dpx = 0;
                end
            end
            m_state = nc;
        end
        @(negedge clk);
        chk(tag, "state", int'(link_state), m_state);
        chk(tag, "pulse", int'(change_pulse), m_pulse);
        chk(tag, "speed", int'(link_speed), m_spd);
        chk(tag, "duplex", int'(link_duplex), m_dpx);
        chk(tag, "up_count", int'(up_count), m_up % (1 << CW));
        chk(tag, "drop_count", int'(drop_count), m_drop % (1 << CW));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL R11 watchdog expired: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset values
        chk("R10", "reset state", int'(link_state), 2);
        chk("R10", "reset speed", int'(link_speed), 0);
        chk("R10", "reset duplex", int'(link_duplex), 0);
        chk("R10", "reset up", int'(up_count), 0);
        chk("R10", "reset drop", int'(drop_count), 0);
        chk("R10", "reset pulse", int'(change_pulse), 0);

        // R2 / R5: link word just changed -> unknown, boundary, then up
        sample(16'h0024, 5'h1B, 1'b1, "R5");
        chk("R5", "fresh change unknown", int'(link_state), 2);
        advance(SETTLE - 1);
        sample(16'h0024, 5'h1B, 1'b1, "R5");
        chk("R5", "one tick short unknown", int'(link_state), 2);
        advance(1);
        sample(16'h0024, 5'h1B, 1'b1, "R2");
        chk("R2", "settled link up", int'(link_state), 1);
        chk("R8", "speed 100", int'(link_speed), 2);
        chk("R8", "duplex full", int'(link_duplex), 2);
        chk("R9", "up count", int'(up_count), 1);

        // R4: immediate drop
        sample(16'h0020, 5'h1B, 1'b1, "R4");
        chk("R4", "drop at once", int'(link_state), 0);
        chk("R9", "drop count", int'(drop_count), 1);

        // R8: DOWN -> UNKNOWN quiet, then up at 10M half
        sample(16'h0024, 5'h07, 1'b1, "R8");
        chk("R8", "quiet transition no pulse", int'(change_pulse), 0);
        advance(SETTLE);
        sample(16'h0024, 5'h07, 1'b1, "R8");
        chk("R8", "speed 10", int'(link_speed), 1);
        chk("R8", "duplex half", int'(link_duplex), 1);

        // R1 / R6: merged changes restart the window; AN gating
        sample(16'h0020, 5'h07, 1'b1, "R1");
        advance(3);
        sample(16'h0024, 5'h07, 1'b1, "R1");
        advance(3);
        sample(16'h0004, 5'h07, 1'b1, "R1");
        advance(SETTLE - 1);
        sample(16'h0004, 5'h07, 1'b1, "R1");
        chk("R1", "window restarted by last change", int'(link_state), 2);
        advance(1);
        sample(16'h0004, 5'h07, 1'b1, "R6");
        chk("R6", "AN incomplete gives down", int'(link_state), 0);
        sample(16'h0004, 5'h07, 1'b0, "R6");
        chk("R6", "AN disabled ignores bit 5", int'(link_state), 1);

        // R3: invalid word
        sample(16'hFFFF, 5'h07, 1'b0, "R3");
        chk("R3", "all ones down", int'(link_state), 0);
        advance(SETTLE);
        sample(16'hFFFF, 5'h1B, 1'b0, "R3");
        chk("R3", "all ones down when settled", int'(link_state), 0);

        // R12: settled survives tick-counter wrap
        sample(16'h0024, 5'h1B, 1'b1, "R12");
        advance(SETTLE);
        sample(16'h0024, 5'h1B, 1'b1, "R12");
        advance(40);
        sample(16'h0024, 5'h1B, 1'b1, "R12");
        chk("R12", "still up after wrap", int'(link_state), 1);
        sample(16'h0025, 5'h1B, 1'b1, "R12");
        chk("R12", "change after wrap unsettles", int'(link_state), 2);
        advance(SETTLE - 1);
        sample(16'h0025, 5'h1B, 1'b1, "R12");
        advance(1);
        sample(16'h0025, 5'h1B, 1'b1, "R12");

        // R7 sweep over all vendor flags, AN enable, AN complete
        for (int vs = 0; vs < 32; vs++) begin
            for (int an = 0; an < 2; an++) begin
                for (int ad = 0; ad < 2; ad++) begin
                    logic [15:0] w;
                    w = 16'h0004 | (ad[0] ? 16'h0020 : 16'h0000) | 16'h0100;
                    sample(16'h0000, vs[4:0], an[0], "R7");
                    advance(SETTLE);
                    sample(w, vs[4:0], an[0], "R7");
                    advance(SETTLE);
                    sample(w, vs[4:0], an[0], "R7");
                end
            end
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule